// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block is the register file that sits between a 32-bit peripheral register bus and four DMA channel engines. Each channel owns four 32-bit registers: a source address, a destination address, a transfer-count register, and a control word. The bank decodes the control word into named fields and drives those fields straight to the channel engine. It holds the engine's done and error events as sticky status bits. It also merges the enabled status of every channel into one interrupt line.

The bus port is word addressed. Word `n*4 + k` corresponds to byte offset `n*16 + 4*k`, so channel `n` occupies a 16-byte window. Inside the window, `k` selects the register: 0 is source, 1 is destination, 2 is count, 3 is control. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The engine may overwrite a channel's count with the number of units still remaining, and a read then returns that value.

Top module: `dmarb_bank`

## Requirements
- R1: After a synchronous active-low reset, every register of every channel reads 0, all decoded outputs are 0, and `irq_o` is 0.
- R2: Word address `n*4+k` (channel n in 0..3) selects that channel's register k: 0 is source, 1 is destination, 2 is count, 3 is control. A write changes only that register. Source and destination appear on `ch_src_o` and `ch_dst_o` from the cycle after the write.
- R3: The control word decodes as follows, and each field drives its output from the cycle after the write:
  - bit 0: enable
  - bit 2: done-interrupt enable
  - bit 3: burst
  - bit 5: error-interrupt enable
  - bit 6: source-on-system-bus
  - bit 7: destination-on-system-bus
  - bits 10:8: source step code
  - bits 14:12: destination step code
  - bits 19:16: destination request line
  - bits 21:20: unit size
  - bits 27:24: source request line
- R4: Control bits 11, 15, 22, 23 and 31:28 are not stored and always read 0. Writing 0xFFFFFFFF to a control word with clear status reads back 0x0F3F77ED.
- R5: The count register keeps only bits 23:0 of a write. Bits 31:24 read 0.
- R6: A pulse on `eng_cyc_we_i[n]` loads `eng_cyc_i` into channel n's count, and a later read returns that value. If a bus write to the same count lands in the same cycle, the bus value is kept.
- R7: A pulse on `eng_done_i[n]` sets control bit 1 of channel n, and a pulse on `eng_err_i[n]` sets control bit 4. Each bit stays set until a control write carries 0 in that position. Writing 1 to either bit never sets it.
- R8: When an engine event and a clearing control write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when at least one channel has (bit 1 and bit 2) or (bit 4 and bit 5) set. It follows the status in the cycle after the event, with no extra register.
- R10: Bus writes to word addresses 16 and above change no register. Reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW (6) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_done_i | input | NCH | Per-channel transfer-finished pulse |
| eng_err_i | input | NCH | Per-channel error pulse |
| eng_cyc_we_i | input | NCH | Per-channel remaining-count update strobe |
| eng_cyc_i | input | NCH*CYC_W | Per-channel remaining count |
| ch_src_o | output | NCH*32 | Source addresses |
| ch_dst_o | output | NCH*32 | Destination addresses |
| ch_cyc_o | output | NCH*CYC_W | Programmed or remaining counts |
| ch_en_o | output | NCH | Channel enables |
| ch_burst_o | output | NCH | Burst mode |
| ch_src_sys_o | output | NCH | Source on system bus (0: peripheral bus) |
| ch_dst_sys_o | output | NCH | Destination on system bus |
| ch_src_step_o | output | NCH*3 | Source step codes |
| ch_dst_step_o | output | NCH*3 | Destination step codes |
| ch_src_req_o | output | NCH*4 | Source request line (0: no handshake) |
| ch_dst_req_o | output | NCH*4 | Destination request line (0: no handshake) |
| ch_unit_o | output | NCH*2 | Unit size (00 word, 01 half, 10 byte) |
| irq_o | output | 1 | Merged interrupt |

## Verification
Directed patterns come first, each aimed at one question:
- Distinct per-channel address values show whether window decoding confuses neighbours.
- An all-ones control write separates stored bits from unused bits and from the write-one-ignored status bits.
- A hand-built control value shows that each field lands on its own output.
- Event sequences with the interrupt enables off, then on, then cleared, tell the status path apart from the interrupt gating.
- Coincident engine-and-bus traffic resolves the count and status priorities.

A long random phase then mixes in-range and out-of-range writes with engine events. A behavioural model is compared against every output and the read port on every clock.

// File: rtl/dmarb_pkg.sv
// Package: shared layout of the DMA register bank.
// Holds the control word bit positions, the register selector, and the
// decoded per-channel configuration with pack and unpack helpers.
package dmarb_pkg;

    localparam int WIN_WORDS    = 4;          // words per channel window
    localparam int WIN_SHIFT    = 2;          // log2(WIN_WORDS)

    localparam int B_EN         = 0;
    localparam int B_DONE       = 1;
    localparam int B_DONE_IE    = 2;
    localparam int B_BURST      = 3;
    localparam int B_ERR        = 4;
    localparam int B_ERR_IE     = 5;
    localparam int B_SRC_SYS    = 6;
    localparam int B_DST_SYS    = 7;
    localparam int B_SRC_STEP   = 8;
    localparam int B_DST_STEP   = 12;
    localparam int B_DST_REQ    = 16;
    localparam int B_UNIT       = 20;
    localparam int B_SRC_REQ    = 24;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] src_req;
        logic [1:0] unit;
        logic [3:0] dst_req;
        logic [2:0] dst_step;
        logic [2:0] src_step;
        logic       dst_sys;
        logic       src_sys;
        logic       err_ie;
        logic       burst;
        logic       done_ie;
        logic       en;
    } ch_cfg_t;

    // Extract the stored configuration fields from a bus word.
    function automatic ch_cfg_t cfg_from_word(input logic [31:0] w);
        ch_cfg_t c;
        c.en       = w[B_EN];
        c.done_ie  = w[B_DONE_IE];
        c.burst    = w[B_BURST];
        c.err_ie   = w[B_ERR_IE];
        c.src_sys  = w[B_SRC_SYS];
        c.dst_sys  = w[B_DST_SYS];
        c.src_step = w[B_SRC_STEP +: 3];
        c.dst_step = w[B_DST_STEP +: 3];
        c.dst_req  = w[B_DST_REQ +: 4];
        c.unit     = w[B_UNIT +: 2];
        c.src_req  = w[B_SRC_REQ +: 4];
        return c;
    endfunction

    // Place configuration fields back at their bus positions; others zero.
    function automatic logic [31:0] word_from_cfg(input ch_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[B_EN]            = c.en;
        w[B_DONE_IE]       = c.done_ie;
        w[B_BURST]         = c.burst;
        w[B_ERR_IE]        = c.err_ie;
        w[B_SRC_SYS]       = c.src_sys;
        w[B_DST_SYS]       = c.dst_sys;
        w[B_SRC_STEP +: 3] = c.src_step;
        w[B_DST_STEP +: 3] = c.dst_step;
        w[B_DST_REQ +: 4]  = c.dst_req;
        w[B_UNIT +: 2]     = c.unit;
        w[B_SRC_REQ +: 4]  = c.src_req;
        return w;
    endfunction

endpackage

// File: rtl/dmarb_decode.sv
// Module: word-address decoder.
// Splits the word address into a channel window and a register selector.
// Produces a one-hot write select per channel.
// Assumes the windows are packed from word 0 upward; anything past the last
// window is out of range.
module dmarb_decode
    import dmarb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 6,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    output logic [NCH-1:0]  wr_sel,
    output reg_sel_e        reg_sel,
    output logic [CH_W-1:0] rd_ch,
    output logic            in_range
);

    logic [AW-1:0] win;

    // Window index and range check from the upper address bits.
    always_comb begin
        win      = bus_addr >> WIN_SHIFT;
        in_range = (win < AW'(NCH));
        rd_ch    = win[CH_W-1:0];
        reg_sel  = reg_sel_e'(bus_addr[WIN_SHIFT-1:0]);
    end

    // One write select per channel window.
    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign wr_sel[g] = bus_wr && in_range && (win == AW'(g));
    end

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)) else $error("AST_ONE_WINDOW"); // R2

    AST_OOR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr >= AW'(NCH * WIN_WORDS))) |-> (wr_sel == '0))
        else $error("AST_OOR_NO_SELECT"); // R10

endmodule

// File: rtl/dmarb_chan.sv
// Module: register set of one DMA channel.
// Holds source, destination, count, configuration and two sticky status bits.
// Assumes at most one bus write per cycle. Engine events are single-cycle
// pulses.
// Priority rules: a bus count write beats an engine count update, and an
// engine status set beats a software clear.
module dmarb_chan
    import dmarb_pkg::*;
#(
    parameter int CYC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  reg_sel_e         reg_sel,
    input  logic [31:0]      wdata,
    input  logic             done_set,
    input  logic             err_set,
    input  logic             cnt_we,
    input  logic [CYC_W-1:0] cnt_val,
    output logic [31:0]      src,
    output logic [31:0]      dst,
    output logic [CYC_W-1:0] cnt,
    output ch_cfg_t          cfg,
    output logic             sts_done,
    output logic             sts_err,
    output logic [31:0]      rd_word
);

    logic ctrl_wr;
    logic done_nxt;
    logic err_nxt;

    // Control write strobe and next status: clear on written 0, set wins.
    always_comb begin
        ctrl_wr  = wr_sel && (reg_sel == SEL_CTRL);
        done_nxt = sts_done;
        err_nxt  = sts_err;
        if (ctrl_wr && !wdata[B_DONE]) done_nxt = 1'b0;
        if (ctrl_wr && !wdata[B_ERR])  err_nxt  = 1'b0;
        if (done_set) done_nxt = 1'b1;
        if (err_set)  err_nxt  = 1'b1;
    end

    // Address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
        end else if (wr_sel) begin
            if (reg_sel == SEL_SRC) src <= wdata;
            if (reg_sel == SEL_DST) dst <= wdata;
        end
    end

    // Count register: a bus write overrides an engine update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_sel && (reg_sel == SEL_CNT))
            cnt <= wdata[CYC_W-1:0];
        else if (cnt_we)
            cnt <= cnt_val;
    end

    // Configuration fields and sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            sts_done <= 1'b0;
            sts_err  <= 1'b0;
        end else begin
            if (ctrl_wr) cfg <= cfg_from_word(wdata);
            sts_done <= done_nxt;
            sts_err  <= err_nxt;
        end
    end

    // Read view of the selected register.
    always_comb begin
        unique case (reg_sel)
            SEL_SRC: rd_word = src;
            SEL_DST: rd_word = dst;
            SEL_CNT: rd_word = 32'(cnt);
            default: begin
                rd_word         = word_from_cfg(cfg);
                rd_word[B_DONE] = sts_done;
                rd_word[B_ERR]  = sts_err;
            end
        endcase
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_done && !(ctrl_wr && !wdata[B_DONE])) |=> sts_done)
        else $error("AST_DONE_STICKY"); // R7

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_done && !done_set) |=> !sts_done)
        else $error("AST_NO_SW_SET"); // R7

    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> sts_done) else $error("AST_DONE_SET_WINS"); // R8

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> sts_err) else $error("AST_ERR_SET_WINS"); // R8

    AST_CNT_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (reg_sel == SEL_CNT) && cnt_we) |=> (cnt == $past(wdata[CYC_W-1:0])))
        else $error("AST_CNT_BUS_WINS"); // R6

endmodule

// File: rtl/dmarb_irq.sv
// Module: interrupt merge.
// Combines each channel's status bits with their own enables and ORs all
// channels into one line.
// Purely combinational, so the line follows the status registers directly.
module dmarb_irq #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] sts_done,
    input  logic [NCH-1:0] sts_err,
    input  logic [NCH-1:0] done_ie,
    input  logic [NCH-1:0] err_ie,
    output logic           irq
);

    logic [NCH-1:0] ch_req;

    // Per-channel request from gated status.
    for (genvar g = 0; g < NCH; g++) begin : g_req
        assign ch_req[g] = (sts_done[g] && done_ie[g]) || (sts_err[g] && err_ie[g]);
    end

    // Shared line.
    assign irq = |ch_req;

endmodule

// File: rtl/dmarb_bank.sv
// Module: four-channel DMA register bank (top).
// Decodes a word-addressed register bus into per-channel register sets.
// Fans the decoded control fields out to the engines and merges status into
// one interrupt.
// Assumes single-cycle bus writes and combinational reads.
module dmarb_bank
    import dmarb_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 6,
    parameter int CYC_W = 24,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NCH-1:0]     eng_done_i,
    input  logic [NCH-1:0]     eng_err_i,
    input  logic [NCH-1:0]     eng_cyc_we_i,
    input  logic [NCH*CYC_W-1:0] eng_cyc_i,
    output logic [NCH*32-1:0]  ch_src_o,
    output logic [NCH*32-1:0]  ch_dst_o,
    output logic [NCH*CYC_W-1:0] ch_cyc_o,
    output logic [NCH-1:0]     ch_en_o,
    output logic [NCH-1:0]     ch_burst_o,
    output logic [NCH-1:0]     ch_src_sys_o,
    output logic [NCH-1:0]     ch_dst_sys_o,
    output logic [NCH*3-1:0]   ch_src_step_o,
    output logic [NCH*3-1:0]   ch_dst_step_o,
    output logic [NCH*4-1:0]   ch_src_req_o,
    output logic [NCH*4-1:0]   ch_dst_req_o,
    output logic [NCH*2-1:0]   ch_unit_o,
    output logic               irq_o
);

    logic [NCH-1:0]  wr_sel;
    reg_sel_e        reg_sel;
    logic [CH_W-1:0] rd_ch;
    logic            in_range;
    logic [31:0]     rd_words [NCH];
    ch_cfg_t         cfg_w    [NCH];
    logic [NCH-1:0]  done_w;
    logic [NCH-1:0]  err_w;
    logic [NCH-1:0]  done_ie_w;
    logic [NCH-1:0]  err_ie_w;

    dmarb_decode #(.NCH(NCH), .AW(AW)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_sel   (wr_sel),
        .reg_sel  (reg_sel),
        .rd_ch    (rd_ch),
        .in_range (in_range)
    );

    // One register set per channel, with its decoded fields flattened out.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmarb_chan #(.CYC_W(CYC_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_sel[g]),
            .reg_sel  (reg_sel),
            .wdata    (bus_wdata),
            .done_set (eng_done_i[g]),
            .err_set  (eng_err_i[g]),
            .cnt_we   (eng_cyc_we_i[g]),
            .cnt_val  (eng_cyc_i[g*CYC_W +: CYC_W]),
            .src      (ch_src_o[g*32 +: 32]),
            .dst      (ch_dst_o[g*32 +: 32]),
            .cnt      (ch_cyc_o[g*CYC_W +: CYC_W]),
            .cfg      (cfg_w[g]),
            .sts_done (done_w[g]),
            .sts_err  (err_w[g]),
            .rd_word  (rd_words[g])
        );
        assign ch_en_o[g]              = cfg_w[g].en;
        assign ch_burst_o[g]           = cfg_w[g].burst;
        assign ch_src_sys_o[g]         = cfg_w[g].src_sys;
        assign ch_dst_sys_o[g]         = cfg_w[g].dst_sys;
        assign ch_src_step_o[g*3 +: 3] = cfg_w[g].src_step;
        assign ch_dst_step_o[g*3 +: 3] = cfg_w[g].dst_step;
        assign ch_src_req_o[g*4 +: 4]  = cfg_w[g].src_req;
        assign ch_dst_req_o[g*4 +: 4]  = cfg_w[g].dst_req;
        assign ch_unit_o[g*2 +: 2]     = cfg_w[g].unit;
        assign done_ie_w[g]            = cfg_w[g].done_ie;
        assign err_ie_w[g]             = cfg_w[g].err_ie;
    end

    // Read data: selected channel's word, zero outside the windows.
    always_comb begin
        bus_rdata = '0;
        if (in_range) bus_rdata = rd_words[rd_ch];
    end

    dmarb_irq #(.NCH(NCH)) u_irq (
        .sts_done (done_w),
        .sts_err  (err_w),
        .done_ie  (done_ie_w),
        .err_ie   (err_ie_w),
        .irq      (irq_o)
    );

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_w == '0) && (err_w == '0)) |-> !irq_o) else $error("AST_IRQ_QUIET"); // R9

    AST_OOR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_range) |=> ($stable(ch_src_o) && $stable(ch_dst_o)))
        else $error("AST_OOR_WR_IGNORED"); // R10

    AST_OOR_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (bus_rdata == '0)) else $error("AST_OOR_RD_ZERO"); // R10

endmodule

// File: tb/dmarb_bank_tb_top.sv
// Bench: behavioural model of the register bank, compared on every clock,
// plus directed checks with hand-computed values.
module dmarb_bank_tb_top;

    localparam logic [31:0] CFG_MASK = 32'h0F3F_77ED;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  eng_done_i = '0, eng_err_i = '0, eng_cyc_we_i = '0;
    logic [95:0] eng_cyc_i = '0;
    logic [127:0] ch_src_o, ch_dst_o;
    logic [95:0] ch_cyc_o;
    logic [3:0]  ch_en_o, ch_burst_o, ch_src_sys_o, ch_dst_sys_o;
    logic [11:0] ch_src_step_o, ch_dst_step_o;
    logic [15:0] ch_src_req_o, ch_dst_req_o;
    logic [7:0]  ch_unit_o;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    bit checking = 0, finished = 0;

    // Model state.
    logic [31:0] m_src [4];
    logic [31:0] m_dst [4];
    logic [23:0] m_cyc [4];
    logic [31:0] m_cfg [4];
    bit          m_done [4];
    bit          m_err [4];

    always #4 clk = ~clk;

    dmarb_bank dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int c;
        if (a >= 6'd16) return 32'h0;
        c = int'(a[3:2]);
        case (a[1:0])
            2'd0: return m_src[c];
            2'd1: return m_dst[c];
            2'd2: return {8'h0, m_cyc[c]};
            default: return m_cfg[c] | (32'(m_done[c]) << 1) | (32'(m_err[c]) << 4);
        endcase
    endfunction

    function automatic bit m_irq();
        bit r = 0;
        for (int c = 0; c < 4; c++)
            r |= (m_done[c] && m_cfg[c][2]) || (m_err[c] && m_cfg[c][5]);
        return r;
    endfunction

    // Model update on each rising edge from the inputs driven at the falling edge.
    always @(posedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (!rst_n) begin
                m_src[c] = 0; m_dst[c] = 0; m_cyc[c] = 0; m_cfg[c] = 0;
                m_done[c] = 0; m_err[c] = 0;
            end else begin
                if (eng_cyc_we_i[c]) m_cyc[c] = eng_cyc_i[c*24 +: 24];
                if (bus_wr && bus_addr < 6'd16 && int'(bus_addr[3:2]) == c) begin
                    case (bus_addr[1:0])
                        2'd0: m_src[c] = bus_wdata;
                        2'd1: m_dst[c] = bus_wdata;
                        2'd2: m_cyc[c] = bus_wdata[23:0];
                        default: begin
                            m_cfg[c] = bus_wdata & CFG_MASK;
                            if (!bus_wdata[1]) m_done[c] = 0;
                            if (!bus_wdata[4]) m_err[c] = 0;
                        end
                    endcase
                end
                if (eng_done_i[c]) m_done[c] = 1;
                if (eng_err_i[c])  m_err[c] = 1;
            end
        end
    end

    // Every-cycle comparison of all outputs against the model.
    always @(negedge clk) begin
        if (checking) begin
            for (int c = 0; c < 4; c++) begin
                logic [127:0] a, e;
                a = {ch_src_o[c*32 +: 32], ch_dst_o[c*32 +: 32], ch_cyc_o[c*24 +: 24],
                     ch_en_o[c], ch_burst_o[c], ch_src_sys_o[c], ch_dst_sys_o[c],
                     ch_src_step_o[c*3 +: 3], ch_dst_step_o[c*3 +: 3],
                     ch_src_req_o[c*4 +: 4], ch_dst_req_o[c*4 +: 4], ch_unit_o[c*2 +: 2]};
                e = {m_src[c], m_dst[c], m_cyc[c],
                     m_cfg[c][0], m_cfg[c][3], m_cfg[c][6], m_cfg[c][7],
                     m_cfg[c][10:8], m_cfg[c][14:12],
                     m_cfg[c][27:24], m_cfg[c][19:16], m_cfg[c][21:20]};
                chk(a == e, "R2 R3 per-cycle outputs", a, e);
            end
            chk(irq_o == m_irq(), "R9 per-cycle irq", 128'(irq_o), 128'(m_irq()));
        end
    end

    // One bus/engine cycle: drive at the falling edge, then check the read port.
    task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d,
                        input logic [3:0] dn, input logic [3:0] er,
                        input logic [3:0] cwe, input logic [95:0] cv);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        eng_done_i = dn; eng_err_i = er; eng_cyc_we_i = cwe; eng_cyc_i = cv;
        #1;
        chk(bus_rdata == m_read(a), "R2 R10 read port", 128'(bus_rdata), 128'(m_read(a)));
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(1'b1, a, d, 4'h0, 4'h0, 4'h0, '0);
    endtask

    task automatic idle();
        step(1'b0, 6'd0, 32'h0, 4'h0, 4'h0, 4'h0, '0);
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_wr = 0; eng_done_i = 0; eng_err_i = 0; eng_cyc_we_i = 0;
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, tag, 128'(bus_rdata), 128'(exp));
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        checking = 1;
        // R1: reset values
        for (int a = 0; a < 16; a++) rd_exp(6'(a), 32'h0, "R1 reset read");
        chk(irq_o == 1'b0, "R1 reset irq", 128'(irq_o), 128'h0);

        // R2: distinct addresses per channel
        for (int c = 0; c < 4; c++) begin
            wr(6'(c*4),     32'h1000_0000 + 32'(c) * 32'h0101_0011);
            wr(6'(c*4 + 1), 32'h8000_0040 + 32'(c) * 32'h0030_0100);
        end
        for (int c = 0; c < 4; c++) begin
            rd_exp(6'(c*4),     32'h1000_0000 + 32'(c) * 32'h0101_0011, "R2 src readback");
            rd_exp(6'(c*4 + 1), 32'h8000_0040 + 32'(c) * 32'h0030_0100, "R2 dst readback");
        end

        // R4/R7: all-ones control keeps only stored bits; status not set by a 1
        wr(6'd7, 32'hFFFF_FFFF);
        rd_exp(6'd7, 32'h0F3F_77ED, "R4 R7 ctrl all ones");

        // R3: hand-built control value on channel 2
        wr(6'd11, 32'h0529_5349);
        idle();
        chk({ch_en_o[2], ch_burst_o[2], ch_src_sys_o[2], ch_dst_sys_o[2], ch_src_step_o[8:6],
             ch_dst_step_o[8:6], ch_dst_req_o[11:8], ch_src_req_o[11:8], ch_unit_o[5:4]}
            == {1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 3'd5, 4'd9, 4'd5, 2'd2},
            "R3 field decode", 128'({ch_src_step_o[8:6], ch_dst_step_o[8:6], ch_dst_req_o[11:8]}),
            128'({3'd3, 3'd5, 4'd9}));

        // R5: count width
        wr(6'd6, 32'hABCD_EF12);
        rd_exp(6'd6, 32'h00CD_EF12, "R5 count upper bits");

        // R6: engine update, then coincident bus write wins
        step(1'b0, 6'd0, 32'h0, 4'h0, 4'h0, 4'b0001, {72'h0, 24'h12_3456});
        rd_exp(6'd2, 32'h0012_3456, "R6 engine count update");
        step(1'b1, 6'd2, 32'h0000_0777, 4'h0, 4'h0, 4'b0001, {72'h0, 24'h00_0999});
        rd_exp(6'd2, 32'h0000_0777, "R6 bus beats engine");

        // R7/R9: done on channel 3 with enable off, then on, then cleared
        step(1'b0, 6'd0, 32'h0, 4'b1000, 4'h0, 4'h0, '0);
        rd_exp(6'd15, 32'h0000_0002, "R7 done set");
        chk(irq_o == 1'b0, "R9 irq gated off", 128'(irq_o), 128'h0);
        wr(6'd15, 32'h0000_0006);
        idle();
        chk(irq_o == 1'b1, "R9 irq done enabled", 128'(irq_o), 128'h1);
        wr(6'd15, 32'h0000_0004);
        rd_exp(6'd15, 32'h0000_0004, "R7 done cleared by zero");
        chk(irq_o == 1'b0, "R9 irq after clear", 128'(irq_o), 128'h0);

        // R7/R9: error on channel 0
        wr(6'd3, 32'h0000_0020);
        step(1'b0, 6'd0, 32'h0, 4'h0, 4'b0001, 4'h0, '0);
        idle();
        chk(irq_o == 1'b1, "R9 irq error enabled", 128'(irq_o), 128'h1);
        rd_exp(6'd3, 32'h0000_0030, "R7 error set");

        // R8: set and clear in the same cycle
        step(1'b1, 6'd15, 32'h0000_0004, 4'b1000, 4'h0, 4'h0, '0);
        rd_exp(6'd15, 32'h0000_0006, "R8 set beats clear");
        wr(6'd15, 32'h0);
        wr(6'd3, 32'h0);

        // R10: writes past the last window
        wr(6'd16, 32'hDEAD_BEEF);
        wr(6'd33, 32'hDEAD_BEEF);
        wr(6'd63, 32'hDEAD_BEEF);
        rd_exp(6'd0, 32'h1000_0000, "R10 ch0 src untouched");
        rd_exp(6'd16, 32'h0, "R10 out-of-range read");
        rd_exp(6'd63, 32'h0, "R10 out-of-range read top");

        // Mixed traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], (r[3:1] == 3'd7) ? 6'(16 + r[9:4]) : 6'(r[7:4]), $urandom,
                 (r[12:10] == 3'd0) ? 4'(1 << r[14:13]) : 4'h0,
                 (r[17:15] == 3'd0) ? 4'(1 << r[19:18]) : 4'h0,
                 (r[22:20] == 3'd0) ? 4'(1 << r[24:23]) : 4'h0,
                 {$urandom, $urandom, $urandom});
        end
        idle();

        checking = 0;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule